// File: doc/BRIEF.md
# Break-Before-Make Gate Hand-Off Sequencer

This block sits between a PWM modulator and the two gate drivers of a synchronous buck stage. It takes a single PWM request and produces two gate enables: one for the high-side switch and one for the low-side switch. A switch is turned on only after the opposite gate has been reported discharged, and then only after a fixed count of clock cycles. The discharge reports come from two analog comparators. Each one says that its gate has dropped below its turn-off threshold. The block therefore adapts to the real fall time of each gate instead of trusting a fixed dead band.

The PWM request and both comparator flags enter through two-flop synchronizers. There are three force inputs, all synchronous to the block clock. Shutdown and fault-float both park the stage with both enables low. An overvoltage clamp holds the low side on and the high side off, and it still obeys the hand-off rule. The hand-off delay is the parameter `DT_CYCLES`. Its default of 5 cycles gives 40 ns at 125 MHz, which keeps the added delay well under the 100 ns ceiling.

Top module: `gate_handoff_seq`

## Requirements
- R1: After the high-side enable is requested, it stays 0 for as long as the low-gate flag `lo_gate_off` (1 = low gate below threshold) stays 0.
- R2: After the low-side enable is requested, it stays 0 for as long as the high-gate flag `hi_gate_off` (1 = high gate-to-phase voltage below threshold) stays 0.
- R3: Suppose a flag asserts while the block waits for it. The waiting enable then rises exactly SYNC_STAGES + 1 + DT_CYCLES clock edges after the flag is applied, which is 8 edges with the defaults.
- R4: A change of `pwm_req` (1 = high side wanted, 0 = low side wanted) drops the conducting enable SYNC_STAGES + 1 edges later, which is 3 edges with the defaults.
- R5: `shutdown_req` or `float_req` at 1 drives both enables to 0 one edge later and holds them there while asserted, whatever `pwm_req` does. After release, the block restarts through the normal hand-off.
- R6: `ov_clamp` at 1 drops the high-side enable one edge later. It then turns the low side on only through the R2/R3 hand-off, and keeps the low side on while asserted, whatever `pwm_req` does.
- R7: `hi_gate_en` and `lo_gate_en` are never 1 together.
- R8: Suppose `pwm_req` reverses while a turn-on delay is counting. The pending turn-on is dropped, that enable never rises, and the previously conducting gate is turned back on through the hand-off.
- R9: During reset both enables are 0. After reset, with `pwm_req` at 0 and the high gate reported off, the low side comes on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwm_req | input | 1 | PWM command, asynchronous; 1 = high side, 0 = low side |
| lo_gate_off | input | 1 | Comparator: low gate below threshold, asynchronous |
| hi_gate_off | input | 1 | Comparator: high gate-to-phase below threshold, asynchronous |
| shutdown_req | input | 1 | Synchronous shutdown, forces both enables low |
| float_req | input | 1 | Synchronous fault float, forces both enables low |
| ov_clamp | input | 1 | Synchronous overvoltage clamp, low side on, high side off |
| hi_gate_en | output | 1 | High-side gate enable |
| lo_gate_en | output | 1 | Low-side gate enable |

## Verification
The bench holds a comparator flag deasserted for many cycles after an enable has been requested. A design that only timed a dead band would switch the other gate on into a still-conducting one. The hand-off latency is checked cycle-exactly on both sides, so a counter that is off by one, or a missing synchronizer stage, shows up as a rise one edge early or late. The bench also reverses PWM in the middle of a delay count: a design that forgot to cancel would pulse the high side on. The overvoltage clamp and the float input are applied while `pwm_req` keeps changing, which exposes any path where PWM still reaches the enables.

// File: rtl/ghs_pkg.sv
package ghs_pkg;
  typedef enum logic [2:0] {
    ST_BOTH_OFF      = 3'd0,
    ST_WAIT_LOW_OFF  = 3'd1,
    ST_DELAY_HIGH    = 3'd2,
    ST_HIGH_ON       = 3'd3,
    ST_WAIT_HIGH_OFF = 3'd4,
    ST_DELAY_LOW     = 3'd5,
    ST_LOW_ON        = 3'd6
  } ghs_state_e;
endpackage

// File: rtl/ghs_sync_bank.sv
module ghs_sync_bank #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_async[b]};
    end
    assign q_sync[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/ghs_dt_timer.sv
module ghs_dt_timer #(
  parameter int DT_CYCLES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CNT_W = (DT_CYCLES > 1) ? $clog2(DT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign done   = run && (cnt_q == LAST);
  assign cnt_en = !run || !done;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)        cnt_d = '0;
    else if (!done)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run && !done |=> cnt_q != '0);
endmodule

// File: rtl/ghs_fsm.sv
module ghs_fsm
  import ghs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic want_hi,
  input  logic force_off,
  input  logic lo_off_s,
  input  logic hi_off_s,
  input  logic tmr_done,
  output logic tmr_run,
  output logic hi_en,
  output logic lo_en
);
  ghs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (force_off) begin
      state_d = ST_BOTH_OFF;
    end else begin
      unique case (state_q)
        ST_BOTH_OFF:      state_d = want_hi ? ST_WAIT_LOW_OFF : ST_WAIT_HIGH_OFF;
        ST_WAIT_LOW_OFF:  if (!want_hi)      state_d = ST_WAIT_HIGH_OFF;
                          else if (lo_off_s) state_d = ST_DELAY_HIGH;
        ST_DELAY_HIGH:    if (!want_hi)       state_d = ST_WAIT_HIGH_OFF;
                          else if (!lo_off_s) state_d = ST_WAIT_LOW_OFF;
                          else if (tmr_done)  state_d = ST_HIGH_ON;
        ST_HIGH_ON:       if (!want_hi) state_d = ST_WAIT_HIGH_OFF;
        ST_WAIT_HIGH_OFF: if (want_hi)       state_d = ST_WAIT_LOW_OFF;
                          else if (hi_off_s) state_d = ST_DELAY_LOW;
        ST_DELAY_LOW:     if (want_hi)        state_d = ST_WAIT_LOW_OFF;
                          else if (!hi_off_s) state_d = ST_WAIT_HIGH_OFF;
                          else if (tmr_done)  state_d = ST_LOW_ON;
        ST_LOW_ON:        if (want_hi) state_d = ST_WAIT_LOW_OFF;
        default:          state_d = ST_BOTH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_BOTH_OFF;
    else        state_q <= state_d;
  end

  assign tmr_run = (state_q == ST_DELAY_HIGH) || (state_q == ST_DELAY_LOW);
  assign hi_en   = (state_q == ST_HIGH_ON);
  assign lo_en   = (state_q == ST_LOW_ON);

  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_en && lo_en));
  assert_hi_after_lo_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_en) |-> $past(lo_off_s) && $past(tmr_done));
  assert_lo_after_hi_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_en) |-> $past(hi_off_s) && $past(tmr_done));
  assert_force_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |=> !hi_en && !lo_en);
endmodule

// File: rtl/gate_handoff_seq.sv
module gate_handoff_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int DT_CYCLES   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_req,
  input  logic lo_gate_off,
  input  logic hi_gate_off,
  input  logic shutdown_req,
  input  logic float_req,
  input  logic ov_clamp,
  output logic hi_gate_en,
  output logic lo_gate_en
);
  localparam int N_ASYNC = 3;

  logic [1:0]         rst_pipe_q;
  logic               rst_sn;
  logic [N_ASYNC-1:0] raw_in, syn_in;
  logic               want_hi, force_off, tmr_run, tmr_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  assign raw_in = {pwm_req, hi_gate_off, lo_gate_off};

  ghs_sync_bank #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sn), .d_async(raw_in), .q_sync(syn_in)
  );

  assign want_hi   = syn_in[2] && !ov_clamp;
  assign force_off = shutdown_req || float_req;

  ghs_dt_timer #(.DT_CYCLES(DT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_sn), .run(tmr_run), .done(tmr_done)
  );

  ghs_fsm u_fsm (
    .clk(clk), .rst_n(rst_sn), .want_hi(want_hi), .force_off(force_off),
    .lo_off_s(syn_in[0]), .hi_off_s(syn_in[1]), .tmr_done(tmr_done),
    .tmr_run(tmr_run), .hi_en(hi_gate_en), .lo_en(lo_gate_en)
  );

  assert_ov_hi_off_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    ov_clamp && !force_off |=> !hi_gate_en);
  assert_ov_keeps_low_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    ov_clamp && !force_off && lo_gate_en |=> lo_gate_en);
endmodule

// File: tb/sim_gate_handoff_seq.sv
module sim_gate_handoff_seq;
  logic clk, rst_n, pwm_req, lo_gate_off, hi_gate_off;
  logic shutdown_req, float_req, ov_clamp, hi_gate_en, lo_gate_en;
  int checks = 0, errors = 0;
  bit overlap_seen = 0, done = 0;

  localparam int HAND = 2 + 1 + 5;

  gate_handoff_seq u0 (.*);

  initial clk = 0;
  always #4 clk = ~clk;

  always @(negedge clk) if (rst_n && hi_gate_en && lo_gate_en) overlap_seen = 1;

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic nwait(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hold_check(string tag, int n, logic hi_exp, logic lo_exp);
    bit bad_hi = 0, bad_lo = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (hi_gate_en !== hi_exp) bad_hi = 1;
      if (lo_gate_en !== lo_exp) bad_lo = 1;
    end
    chk({tag, " hi held"}, bad_hi ? ~hi_exp : hi_exp, hi_exp);
    chk({tag, " lo held"}, bad_lo ? ~lo_exp : lo_exp, lo_exp);
  endtask

  task automatic wait_rise(string tag, bit want_hi_side, int limit);
    bit seen = 0;
    for (int i = 0; i < limit && !seen; i++) begin
      @(negedge clk);
      if (want_hi_side ? hi_gate_en : lo_gate_en) seen = 1;
    end
    chk(tag, seen, 1'b1);
  endtask

  task automatic t_reset;
    pwm_req = 0; lo_gate_off = 1; hi_gate_off = 1;
    shutdown_req = 0; float_req = 0; ov_clamp = 0;
    rst_n = 0;
    nwait(5);
    chk("R9 reset hi", hi_gate_en, 1'b0);
    chk("R9 reset lo", lo_gate_en, 1'b0);
    rst_n = 1;
    wait_rise("R9 low side after reset", 1'b0, 30);
    chk("R9 hi off after reset", hi_gate_en, 1'b0);
    lo_gate_off = 0;
  endtask

  task automatic t_low_to_high;
    pwm_req = 1;
    nwait(2); chk("R4 lo still on", lo_gate_en, 1'b1);
    nwait(1); chk("R4 lo dropped", lo_gate_en, 1'b0);
    hold_check("R1 waits lo flag", 30, 1'b0, 1'b0);
    lo_gate_off = 1;
    nwait(HAND - 1); chk("R3 hi not early", hi_gate_en, 1'b0);
    nwait(1);        chk("R3 hi on time", hi_gate_en, 1'b1);
    hi_gate_off = 0;
  endtask

  task automatic t_high_to_low;
    pwm_req = 0;
    nwait(2); chk("R4 hi still on", hi_gate_en, 1'b1);
    nwait(1); chk("R4 hi dropped", hi_gate_en, 1'b0);
    hold_check("R2 waits hi flag", 30, 1'b0, 1'b0);
    hi_gate_off = 1;
    nwait(HAND - 1); chk("R3 lo not early", lo_gate_en, 1'b0);
    nwait(1);        chk("R3 lo on time", lo_gate_en, 1'b1);
    lo_gate_off = 0;
  endtask

  task automatic t_reversal;
    pwm_req = 1;
    nwait(3); chk("R8 lo dropped", lo_gate_en, 1'b0);
    lo_gate_off = 1;
    nwait(3);
    pwm_req = 0;
    hold_check("R8 cancel", 8, 1'b0, 1'b0);
    wait_rise("R8 low side back", 1'b0, 30);
    chk("R8 hi never rose", hi_gate_en, 1'b0);
    lo_gate_off = 0;
  endtask

  task automatic go_high;
    pwm_req = 1;
    nwait(3); lo_gate_off = 1;
    nwait(HAND); chk("R3 hi reached", hi_gate_en, 1'b1);
    hi_gate_off = 0;
  endtask

  task automatic t_overvoltage;
    go_high();
    ov_clamp = 1;
    nwait(1); chk("R6 hi dropped", hi_gate_en, 1'b0);
    hold_check("R6 break before make", 20, 1'b0, 1'b0);
    hi_gate_off = 1;
    nwait(HAND - 1); chk("R6 lo not early", lo_gate_en, 1'b0);
    nwait(1);        chk("R6 lo on", lo_gate_en, 1'b1);
    lo_gate_off = 0;
    hold_check("R6 pwm ignored", 20, 1'b0, 1'b1);
    ov_clamp = 0;
    nwait(1); chk("R6 release drops lo", lo_gate_en, 1'b0);
    lo_gate_off = 1;
    wait_rise("R6 high back after release", 1'b1, 20);
    hi_gate_off = 0;
  endtask

  task automatic t_shutdown;
    shutdown_req = 1;
    nwait(1);
    chk("R5 sd hi", hi_gate_en, 1'b0);
    chk("R5 sd lo", lo_gate_en, 1'b0);
    hi_gate_off = 1;
    hold_check("R5 sd held", 20, 1'b0, 1'b0);
    shutdown_req = 0;
    wait_rise("R5 restart after sd", 1'b1, 20);
    hi_gate_off = 0;
  endtask

  task automatic t_float;
    pwm_req = 0;
    nwait(3); hi_gate_off = 1;
    nwait(HAND); chk("R5 low reached", lo_gate_en, 1'b1);
    lo_gate_off = 0;
    float_req = 1;
    nwait(1);
    chk("R5 float hi", hi_gate_en, 1'b0);
    chk("R5 float lo", lo_gate_en, 1'b0);
    lo_gate_off = 1;
    pwm_req = 1;
    hold_check("R5 float held", 10, 1'b0, 1'b0);
    pwm_req = 0;
    hold_check("R5 float held pwm low", 10, 1'b0, 1'b0);
    pwm_req = 1;
    nwait(4);
    float_req = 0;
    wait_rise("R5 restart after float", 1'b1, 20);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_low_to_high();
    t_high_to_low();
    t_reversal();
    t_overvoltage();
    t_shutdown();
    t_float();
    chk("R7 enables never overlapped", overlap_seen, 1'b0);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule